// File: doc/BRIEF.md
# Lockable Memory Row Boundary Decoder

This block maps a physical address onto one of a small set of memory rows. Software programs one boundary byte per row. Each byte holds the running total of memory in that row and all lower rows, counted in 32 MB units, so a value of 1 stands for 32 MB. When an address strobe arrives, the top seven address bits (A[31:25]) are compared with every boundary. The address belongs to the lowest-numbered row whose boundary is above it. An address that no boundary covers raises a miss.

The boundary bytes sit behind a byte-wide register port at offsets 60h–63h. Offsets 64h–67h form a reserved window. A lock input freezes the boundaries, and while it is high all register writes are discarded. The decode result is held in a register, so it appears exactly one clock after the strobe.

Top module: `row_bound_decoder`

## Requirements
- R1: After reset every boundary reads 00h, and `dec_valid_o`, `row_sel_o`, `hit_o` and `miss_o` are all 0.
- R2: A write with `reg_we_i`=1 at offset 60h+N (N=0..3) stores the value into row N's boundary. `reg_rdata_o` shows the register addressed by `reg_addr_i` combinationally, in the same cycle.
- R3: Bit 7 of every boundary always reads 0, and a 1 written to bit 7 is discarded.
- R4: Writes to offsets 64h–67h change no boundary. Reads from 64h–67h, and from any offset outside 60h–67h, return 00h.
- R5: While `lock_i`=1, writes to any offset leave every boundary unchanged.
- R6: For a strobed address with field F = A[31:25], `row_sel_o` is one-hot with bit N set, where N is the lowest row whose boundary is greater than F.
- R7: A row whose boundary equals the boundary of the row below it is never selected. A row 0 boundary of 0 means row 0 is never selected.
- R8: If F is greater than or equal to every boundary, `miss_o`=1, `hit_o`=0 and `row_sel_o`=0. Otherwise `hit_o`=1 and `miss_o`=0.
- R9: `dec_valid_o` is 1 in the cycle after a cycle with `addr_valid_i`=1, and 0 otherwise. `row_sel_o`, `hit_o` and `miss_o` change only in the cycle after a strobe, and otherwise keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Makes the boundaries read-only while high |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| addr_valid_i | input | 1 | Address strobe |
| addr_i | input | 32 | Physical address |
| dec_valid_o | output | 1 | Decode result valid |
| row_sel_o | output | 4 | One-hot row select |
| hit_o | output | 1 | Address lies in a row |
| miss_o | output | 1 | Address lies above all rows |

## Verification
Register writes take effect at the clock edge after they are driven. Reads are combinational, so the bench drives each write on a falling edge and reads back after the next falling edge, a little after the offset settles. A decode result is due one edge after its strobe. The bench drives each strobe on a falling edge and compares the select, hit and miss outputs on the following falling edge. It then runs one idle cycle to confirm that the valid flag drops and the outputs hold. Every 7-bit address field is swept under several boundary sets, including sets with empty rows, an all-zero set and a full 1 GB set.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  typedef enum logic [1:0] {
    OFF_NONE = 2'd0,
    OFF_ROW  = 2'd1,
    OFF_RSVD = 2'd2
  } off_kind_e;
endpackage

// File: rtl/rbd_regfile.sv
module rbd_regfile #(
  parameter int ROW_NUM  = 4,
  parameter int REG_NUM  = 8,
  parameter int OFF_W    = 8,
  parameter int REG_W    = 8,
  parameter int LIM_W    = 7,
  parameter int BASE_OFF = 'h60
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            lock_i,
  input  logic                            we_i,
  input  logic [OFF_W-1:0]                addr_i,
  input  logic [LIM_W-1:0]                wdata_i,
  output logic [REG_W-1:0]                rdata_o,
  output logic [ROW_NUM-1:0][LIM_W-1:0]   bounds_o
);
  import rbd_pkg::*;

  localparam int IDX_W = (ROW_NUM > 1) ? $clog2(ROW_NUM) : 1;
  localparam logic [OFF_W-1:0] BASE_B = OFF_W'(BASE_OFF);
  localparam logic [OFF_W-1:0] REGN_B = OFF_W'(REG_NUM);
  localparam logic [OFF_W-1:0] ROWN_B = OFF_W'(ROW_NUM);

  logic [OFF_W-1:0] rel;
  off_kind_e        kind;
  logic [IDX_W-1:0] idx;

  assign rel = addr_i - BASE_B;
  assign idx = rel[IDX_W-1:0];

  always_comb begin
    kind = OFF_NONE;
    if (addr_i >= BASE_B && rel < REGN_B) begin
      kind = (rel < ROWN_B) ? OFF_ROW : OFF_RSVD;
    end
  end

  for (genvar g = 0; g < ROW_NUM; g++) begin : g_row
    logic wr_hit;
    assign wr_hit = we_i && !lock_i && (kind == OFF_ROW) && (idx == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     bounds_o[g] <= '0;
      else if (wr_hit) bounds_o[g] <= wdata_i;
    end
  end

  // bit 7 and reserved space read as zero
  always_comb begin
    rdata_o = '0;
    if (kind == OFF_ROW) rdata_o = {{(REG_W-LIM_W){1'b0}}, bounds_o[idx]};
  end
endmodule

// File: rtl/rbd_row_match.sv
module rbd_row_match #(
  parameter int ROW_NUM = 4,
  parameter int LIM_W   = 7
) (
  input  logic [LIM_W-1:0]              field_i,
  input  logic [ROW_NUM-1:0][LIM_W-1:0] bounds_i,
  output logic [ROW_NUM-1:0]            sel_o,
  output logic                          miss_o
);
  logic [ROW_NUM-1:0] below;

  for (genvar g = 0; g < ROW_NUM; g++) begin : g_cmp
    assign below[g] = field_i < bounds_i[g];
  end

  // lowest row wins
  always_comb begin
    logic found;
    found = 1'b0;
    sel_o = '0;
    for (int i = 0; i < ROW_NUM; i++) begin
      if (below[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
    miss_o = !found;
  end
endmodule

// File: rtl/rbd_out_reg.sv
module rbd_out_reg #(
  parameter int ROW_NUM = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [ROW_NUM-1:0] sel_i,
  input  logic               miss_i,
  output logic               valid_o,
  output logic [ROW_NUM-1:0] sel_o,
  output logic               hit_o,
  output logic               miss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sel_o   <= '0;
      hit_o   <= 1'b0;
      miss_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sel_o  <= sel_i;
        hit_o  <= !miss_i;
        miss_o <= miss_i;
      end
    end
  end
endmodule

// File: rtl/row_bound_decoder.sv
module row_bound_decoder #(
  parameter int ROW_NUM  = 4,
  parameter int REG_NUM  = 8,
  parameter int OFF_W    = 8,
  parameter int REG_W    = 8,
  parameter int LIM_W    = 7,
  parameter int ADDR_W   = 32,
  parameter int BASE_OFF = 'h60
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               lock_i,
  input  logic               reg_we_i,
  input  logic [OFF_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               addr_valid_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               dec_valid_o,
  output logic [ROW_NUM-1:0] row_sel_o,
  output logic               hit_o,
  output logic               miss_o
);
  localparam int FIELD_LSB = ADDR_W - LIM_W;

  logic [ROW_NUM-1:0][LIM_W-1:0] bounds;
  logic [LIM_W-1:0]              field;
  logic [ROW_NUM-1:0]            sel_c;
  logic                          miss_c;
  logic                          unused_bits;

  assign field       = addr_i[ADDR_W-1:FIELD_LSB];
  assign unused_bits = ^{addr_i[FIELD_LSB-1:0], reg_wdata_i[REG_W-1:LIM_W]};

  rbd_regfile #(
    .ROW_NUM(ROW_NUM), .REG_NUM(REG_NUM), .OFF_W(OFF_W),
    .REG_W(REG_W), .LIM_W(LIM_W), .BASE_OFF(BASE_OFF)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i[LIM_W-1:0]),
    .rdata_o  (reg_rdata_o),
    .bounds_o (bounds)
  );

  rbd_row_match #(.ROW_NUM(ROW_NUM), .LIM_W(LIM_W)) u_match (
    .field_i  (field),
    .bounds_i (bounds),
    .sel_o    (sel_c),
    .miss_o   (miss_c)
  );

  rbd_out_reg #(.ROW_NUM(ROW_NUM)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (addr_valid_i),
    .sel_i   (sel_c),
    .miss_i  (miss_c),
    .valid_o (dec_valid_o),
    .sel_o   (row_sel_o),
    .hit_o   (hit_o),
    .miss_o  (miss_o)
  );
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int ROW_NUM = 4,
  parameter int OFF_W   = 8,
  parameter int REG_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lock_i,
  input logic               reg_we_i,
  input logic [OFF_W-1:0]   reg_addr_i,
  input logic [REG_W-1:0]   reg_rdata_o,
  input logic               addr_valid_i,
  input logic               dec_valid_o,
  input logic [ROW_NUM-1:0] row_sel_o,
  input logic               hit_o,
  input logic               miss_o
);
  p_sel_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o));

  p_miss_no_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (row_sel_o == '0) && !hit_o);

  p_hit_xor_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (hit_o != miss_o));

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i |=> dec_valid_o);

  p_valid_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> !dec_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> $stable(row_sel_o) && $stable(miss_o) && $stable(hit_o));

  p_bit7_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[REG_W-1]);

  p_rsvd_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i >= OFF_W'('h64) && reg_addr_i <= OFF_W'('h67)) |-> reg_rdata_o == '0);

  p_lock_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && reg_we_i) |=> (reg_addr_i != $past(reg_addr_i)) ||
                             (reg_rdata_o == $past(reg_rdata_o)));
endmodule

bind row_bound_decoder rbd_checker #(
  .ROW_NUM(ROW_NUM), .OFF_W(OFF_W), .REG_W(REG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lock_i       (lock_i),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o),
  .addr_valid_i (addr_valid_i),
  .dec_valid_o  (dec_valid_o),
  .row_sel_o    (row_sel_o),
  .hit_o        (hit_o),
  .miss_o       (miss_o)
);

// File: tb/row_bound_decoder_tb.sv
`timescale 1ns/1ps
module row_bound_decoder_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        addr_valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        dec_valid_o;
  logic [3:0]  row_sel_o;
  logic        hit_o;
  logic        miss_o;

  int checks = 0;
  int fails  = 0;
  logic [6:0] bnd [4];

  always #2.5 clk_i = ~clk_i;

  row_bound_decoder u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = off; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input logic [7:0] exp);
    reg_addr_i = off;
    #1;
    chk(req, {24'd0, reg_rdata_o}, {24'd0, exp});
  endtask

  task automatic set_bounds(input logic [6:0] b0, input logic [6:0] b1,
                            input logic [6:0] b2, input logic [6:0] b3);
    bnd[0] = b0; bnd[1] = b1; bnd[2] = b2; bnd[3] = b3;
    for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i), {1'b0, bnd[i]});
  endtask

  // expected: lowest row whose boundary exceeds the field
  task automatic sweep(input string req);
    for (int f = 0; f < 128; f++) begin
      logic [3:0] es;
      logic       em;
      es = '0; em = 1'b1;
      for (int i = 0; i < 4; i++)
        if (em && (7'(f) < bnd[i])) begin es[i] = 1'b1; em = 1'b0; end
      @(negedge clk_i);
      addr_valid_i = 1'b1;
      addr_i = {7'(f), 25'(f * 32'h0003_1f5d)};
      @(negedge clk_i);
      addr_valid_i = 1'b0;
      chk(req, {25'd0, dec_valid_o, row_sel_o, hit_o, miss_o}, {25'd0, 1'b1, es, !em, em});
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] s_prev;
    logic       m_prev;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 outputs", {28'd0, dec_valid_o, row_sel_o == 0, hit_o, miss_o}, {28'd0, 4'b0100});
    for (int i = 0; i < 4; i++) rd_chk("R1 reset bound", 8'h60 + 8'(i), 8'h00);

    // R2 write/readback, R3 bit 7 dropped
    set_bounds(7'd4, 7'd8, 7'd16, 7'd32);
    rd_chk("R2 row0", 8'h60, 8'h04);
    rd_chk("R2 row3", 8'h63, 8'h20);
    wr(8'h61, 8'hFF);
    rd_chk("R3 bit7", 8'h61, 8'h7F);
    wr(8'h61, 8'h08);
    rd_chk("R2 row1", 8'h61, 8'h08);

    // R4 reserved and out-of-window offsets
    for (int i = 4; i < 8; i++) begin
      wr(8'h60 + 8'(i), 8'h55);
      rd_chk("R4 rsvd read", 8'h60 + 8'(i), 8'h00);
    end
    rd_chk("R4 below window", 8'h5F, 8'h00);
    rd_chk("R4 above window", 8'h68, 8'h00);
    for (int i = 0; i < 4; i++) rd_chk("R4 rows intact", 8'h60 + 8'(i), {1'b0, bnd[i]});

    // R5 lock
    lock_i = 1'b1;
    for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i), 8'h11);
    for (int i = 0; i < 4; i++) rd_chk("R5 locked", 8'h60 + 8'(i), {1'b0, bnd[i]});
    lock_i = 1'b0;

    // R6/R8 sweep over a 1 GB map
    sweep("R6 R8 graded");
    // R9 idle cycle: valid drops, outputs hold
    s_prev = row_sel_o; m_prev = miss_o;
    @(negedge clk_i);
    chk("R9 idle", {26'd0, dec_valid_o, row_sel_o, miss_o}, {26'd0, 1'b0, s_prev, m_prev});

    // R7 empty rows 1 and 3
    set_bounds(7'd2, 7'd2, 7'd6, 7'd6);
    sweep("R7 empty rows");
    // R7 row 0 empty
    set_bounds(7'd0, 7'd3, 7'd3, 7'd9);
    sweep("R7 row0 empty");
    // R8 all zero: always miss
    set_bounds(7'd0, 7'd0, 7'd0, 7'd0);
    sweep("R8 all miss");
    // R6 single row at top of range
    set_bounds(7'd127, 7'd127, 7'd127, 7'd127);
    sweep("R6 full row0");

    // R9 back-to-back strobes then idle
    set_bounds(7'd1, 7'd2, 7'd3, 7'd4);
    @(negedge clk_i);
    addr_valid_i = 1'b1; addr_i = {7'd2, 25'd0};
    @(negedge clk_i);
    chk("R9 first", {27'd0, dec_valid_o, row_sel_o}, {27'd0, 1'b1, 4'b0100});
    addr_i = {7'd0, 25'h1ff_ffff};
    @(negedge clk_i);
    addr_valid_i = 1'b0; addr_i = {7'd3, 25'd0};
    chk("R9 second", {27'd0, dec_valid_o, row_sel_o}, {27'd0, 1'b1, 4'b0001});
    @(negedge clk_i);
    chk("R9 hold", {27'd0, dec_valid_o, row_sel_o}, {27'd0, 1'b0, 4'b0001});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule